// File: doc/BRIEF.md
# Configurable Trigger Routing Multiplexer

This block routes trigger signals between producers and consumers. Each multiplexer output picks one line from a vector of input triggers. Each output also carries its own conditioning settings. The signal can be inverted. It can then pass straight through as a level, or it can be resynchronised into the local clock and reshaped into a fixed-width pulse. A debug-freeze gate holds the output low while a global freeze input is high, but only for outputs that have opted in. Alongside the multiplexer is a set of dedicated one-to-one lines. Each of these joins one fixed producer input to one fixed consumer output and can be switched on or off by itself.

Settings arrive over a one-cycle write strobe with a 32-bit target word and the field values. The target word picks the kind of target with bit 30 and bit 12, the group with bits 11:8, and the output or line number with bits 7:0. A write that names something this instance does not own, or that asks for an input that does not exist, is refused. A refused write raises a status flag and leaves every stored setting as it was.

Top module: `trig_route_mux`

## Requirements
- R1: A write with bit 30 = 1, bit 12 = 0, bits 11:8 equal to MUX_GROUP, bits 7:0 below N_OUT, bits 31 and 29:13 zero, and a select value below N_IN is accepted. The addressed output takes its new select, enable, invert, edge and freeze settings from the clock edge that samples the strobe, and the error flag reads 0 after that edge.
- R2: After reset every output and every line is disabled and drives 0, invert is off, level mode is selected, freeze is off and the error flag is 0. A disabled output or line drives 0 whatever its input.
- R3: In level mode an enabled, unfrozen multiplexer output equals the selected trigger input XOR its invert bit, with no clock delay.
- R4: In edge mode the signal (input XOR invert) passes through a two-flop synchroniser and a rising-edge detector. A rise that is present before clock edge k drives the output high after edge k+2 and low again after edge k+4, which makes a pulse exactly PULSE_W = 2 cycles wide.
- R5: A rising edge that is detected while a pulse is still active is dropped. The pulse is neither extended nor restarted, and the edge is not queued.
- R6: When an output's freeze bit is 1 and the freeze input is high, the output drives 0. This gate sits after the invert stage. When the freeze bit is 0, the freeze input has no effect.
- R7: A write with bit 30 = 1, bit 12 = 1, bits 11:8 equal to LINE_GROUP, bits 7:0 below N_LINE and the reserved bits zero configures that one-to-one line. Its enable, invert, edge and freeze settings apply to its own line input exactly as they do for the multiplexer outputs, and the select value is ignored.
- R8: A write is refused if bit 30 is 0, if it names the wrong group, if its index is out of range, if any reserved bit is set, or if it is a multiplexer write with a select value of N_IN or more. A refused write sets the error flag to 1 after the sampling edge and changes no stored setting.
- R9: The error flag keeps its value until the next write strobe.
- R10: Each output keeps its own settings. A write to one output leaves the routing of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | One-cycle write strobe |
| cfg_word | input | 32 | Target word: kind, group, index |
| cfg_sel | input | 8 | Input select for multiplexer writes |
| cfg_en | input | 1 | Enable value to store |
| cfg_inv | input | 1 | Invert value to store |
| cfg_edge | input | 1 | 1 = edge mode, 0 = level mode |
| cfg_frz | input | 1 | Debug-freeze enable value to store |
| cfg_err | output | 1 | 1 when the last write was refused |
| trig_in | input | N_IN | Input triggers offered to the multiplexer |
| dbg_freeze | input | 1 | Global freeze request |
| mux_out | output | N_OUT | Conditioned multiplexer outputs |
| line_in | input | N_LINE | One-to-one producer lines |
| line_out | output | N_LINE | Conditioned one-to-one outputs |

## Verification
The hardest case to reach is the dropped re-trigger. A second rising edge has to arrive while the first pulse is still high. To do that, the input must fall and rise again inside two cycles, timed so that its detection lands in the pulse's second cycle. The bench drives the input high, then low on the next falling clock edge, then high on the one after. It then checks that the output falls on schedule and stays low. A second hard case is proving that refused writes leave the settings alone. Straight after each refused write, the bench drives an input pattern whose expected output depends on the settings stored before that write.

// File: rtl/trm_pkg.sv
package trm_pkg;

    // per-output conditioning settings
    typedef struct packed {
        logic en;
        logic inv;
        logic edge_m;
        logic frz;
    } trm_ctl_t;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned SPACE_BIT = 30;
    localparam int unsigned KIND_BIT  = 12;
    localparam int unsigned GRP_LO    = 8;
    localparam int unsigned GRP_W     = 4;
    localparam int unsigned IDX_W     = 8;
    localparam int unsigned SEL_W     = 8;

endpackage

// File: rtl/trm_cfg_regs.sv
module trm_cfg_regs
    import trm_pkg::*;
#(
    parameter int unsigned      N_IN       = 16,
    parameter int unsigned      N_OUT      = 4,
    parameter int unsigned      N_LINE     = 4,
    parameter logic [GRP_W-1:0] MUX_GROUP  = 4'd3,
    parameter logic [GRP_W-1:0] LINE_GROUP = 4'd5,
    localparam int unsigned     IW         = $clog2(N_IN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [WORD_W-1:0]             word,
    input  logic [SEL_W-1:0]              sel,
    input  trm_ctl_t                      ctl_in,
    output trm_ctl_t [N_OUT-1:0]          mux_ctl,
    output logic     [N_OUT-1:0][IW-1:0]  mux_sel,
    output trm_ctl_t [N_LINE-1:0]         line_ctl,
    output logic                          err
);

    typedef struct packed {
        trm_ctl_t [N_OUT-1:0]         mctl;
        logic     [N_OUT-1:0][IW-1:0] msel;
        trm_ctl_t [N_LINE-1:0]        lctl;
        logic                         err;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [IDX_W-1:0] idx;
    logic [GRP_W-1:0] grp;
    logic             rsvd_clr;
    logic             hit_mux;
    logic             hit_line;

    always_comb begin
        idx      = word[IDX_W-1:0];
        grp      = word[GRP_LO +: GRP_W];
        rsvd_clr = (word[WORD_W-1] == 1'b0) && (word[SPACE_BIT-1:KIND_BIT+1] == '0);
        hit_mux  = rsvd_clr && word[SPACE_BIT] && !word[KIND_BIT]
                   && (grp == MUX_GROUP) && (int'(idx) < N_OUT)
                   && (int'(sel) < N_IN);
        hit_line = rsvd_clr && word[SPACE_BIT] && word[KIND_BIT]
                   && (grp == LINE_GROUP) && (int'(idx) < N_LINE);

        st_d = st_q;
        if (we) begin
            st_d.err = !(hit_mux || hit_line);
            for (int i = 0; i < N_OUT; i++) begin
                if (hit_mux && (int'(idx) == i)) begin
                    st_d.mctl[i] = ctl_in;
                    st_d.msel[i] = sel[IW-1:0];
                end
            end
            for (int j = 0; j < N_LINE; j++) begin
                if (hit_line && (int'(idx) == j)) begin
                    st_d.lctl[j] = ctl_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_ctl  = st_q.mctl;
    assign mux_sel  = st_q.msel;
    assign line_ctl = st_q.lctl;
    assign err      = st_q.err;

endmodule

// File: rtl/trm_edge_shaper.sv
module trm_edge_shaper #(
    parameter int unsigned  PULSE_W = 2,
    localparam int unsigned CW      = $clog2(PULSE_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);

    typedef struct packed {
        logic [2:0]    sh;   // [0],[1] synchroniser, [2] previous value
        logic [CW-1:0] cnt;
    } shp_st_t;

    shp_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[1:0], din};
        rise    = st_q.sh[1] && !st_q.sh[2];
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (rise) begin
            st_d.cnt = CW'(PULSE_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = (st_q.cnt != '0);

endmodule

// File: rtl/trm_out_cond.sv
module trm_out_cond
    import trm_pkg::*;
#(
    parameter int unsigned PULSE_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     raw,
    input  trm_ctl_t ctl,
    input  logic     dbg_freeze,
    output logic     out,
    output logic     pulse
);

    logic flipped;
    logic shaped;

    assign flipped = raw ^ ctl.inv;

    trm_edge_shaper #(.PULSE_W(PULSE_W)) u_shaper (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flipped),
        .pulse (pulse)
    );

    always_comb begin
        shaped = ctl.edge_m ? pulse : flipped;
        out    = ctl.en && shaped && !(ctl.frz && dbg_freeze);
    end

endmodule

// File: rtl/trig_route_mux.sv
module trig_route_mux
    import trm_pkg::*;
#(
    parameter int unsigned      N_IN       = 16,
    parameter int unsigned      N_OUT      = 4,
    parameter int unsigned      N_LINE     = 4,
    parameter int unsigned      PULSE_W    = 2,
    parameter logic [GRP_W-1:0] MUX_GROUP  = 4'd3,
    parameter logic [GRP_W-1:0] LINE_GROUP = 4'd5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [31:0]        cfg_word,
    input  logic [7:0]         cfg_sel,
    input  logic               cfg_en,
    input  logic               cfg_inv,
    input  logic               cfg_edge,
    input  logic               cfg_frz,
    output logic               cfg_err,
    input  logic [N_IN-1:0]    trig_in,
    input  logic               dbg_freeze,
    output logic [N_OUT-1:0]   mux_out,
    input  logic [N_LINE-1:0]  line_in,
    output logic [N_LINE-1:0]  line_out
);

    localparam int unsigned IW = $clog2(N_IN);

    trm_ctl_t                     ctl_in;
    trm_ctl_t [N_OUT-1:0]         mux_ctl;
    logic     [N_OUT-1:0][IW-1:0] mux_sel;
    trm_ctl_t [N_LINE-1:0]        line_ctl;
    logic     [N_OUT-1:0]         mux_pulse;
    logic     [N_LINE-1:0]        line_pulse;

    assign ctl_in = '{en: cfg_en, inv: cfg_inv, edge_m: cfg_edge, frz: cfg_frz};

    trm_cfg_regs #(
        .N_IN       (N_IN),
        .N_OUT      (N_OUT),
        .N_LINE     (N_LINE),
        .MUX_GROUP  (MUX_GROUP),
        .LINE_GROUP (LINE_GROUP)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .word     (cfg_word),
        .sel      (cfg_sel),
        .ctl_in   (ctl_in),
        .mux_ctl  (mux_ctl),
        .mux_sel  (mux_sel),
        .line_ctl (line_ctl),
        .err      (cfg_err)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_mux
        logic raw;
        assign raw = trig_in[mux_sel[g]];
        trm_out_cond #(.PULSE_W(PULSE_W)) u_cond (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw        (raw),
            .ctl        (mux_ctl[g]),
            .dbg_freeze (dbg_freeze),
            .out        (mux_out[g]),
            .pulse      (mux_pulse[g])
        );
    end

    for (genvar h = 0; h < N_LINE; h++) begin : g_line
        trm_out_cond #(.PULSE_W(PULSE_W)) u_cond (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw        (line_in[h]),
            .ctl        (line_ctl[h]),
            .dbg_freeze (dbg_freeze),
            .out        (line_out[h]),
            .pulse      (line_pulse[h])
        );
    end

endmodule

// File: rtl/trig_route_mux_chk.sv
module trig_route_mux_chk
    import trm_pkg::*;
#(
    parameter int unsigned  N_IN    = 16,
    parameter int unsigned  N_OUT   = 4,
    parameter int unsigned  N_LINE  = 4,
    parameter int unsigned  PULSE_W = 2,
    localparam int unsigned IW      = $clog2(N_IN),
    localparam int unsigned RW      = $clog2(PULSE_W + 2)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic                         cfg_space,
    input logic                         cfg_err,
    input logic [N_IN-1:0]              trig_in,
    input logic [N_LINE-1:0]            line_in,
    input logic                         dbg_freeze,
    input logic [N_OUT-1:0]             mux_out,
    input logic [N_LINE-1:0]            line_out,
    input trm_ctl_t [N_OUT-1:0]         mux_ctl,
    input logic [N_OUT-1:0][IW-1:0]     mux_sel,
    input trm_ctl_t [N_LINE-1:0]        line_ctl,
    input logic [N_OUT-1:0]             mux_pulse,
    input logic [N_LINE-1:0]            line_pulse
);

    localparam int unsigned NP = N_OUT + N_LINE;
    logic [NP-1:0] all_pulse;
    assign all_pulse = {line_pulse, mux_pulse};

    a_r8_refused_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_space) |=> (cfg_err && $stable(mux_ctl) && $stable(line_ctl)));

    a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_err));

    for (genvar g = 0; g < N_OUT; g++) begin : g_mchk
        a_r2_mux_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !mux_ctl[g].en |-> !mux_out[g]);
        a_r6_mux_frozen_low: assert property (@(posedge clk) disable iff (!rst_n)
            (mux_ctl[g].frz && dbg_freeze) |-> !mux_out[g]);
        a_r3_mux_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (mux_ctl[g].en && !mux_ctl[g].edge_m && !(mux_ctl[g].frz && dbg_freeze))
            |-> (mux_out[g] == (trig_in[mux_sel[g]] ^ mux_ctl[g].inv)));
    end

    for (genvar h = 0; h < N_LINE; h++) begin : g_lchk
        a_r7_line_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !line_ctl[h].en |-> !line_out[h]);
        a_r7_line_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (line_ctl[h].en && !line_ctl[h].edge_m && !(line_ctl[h].frz && dbg_freeze))
            |-> (line_out[h] == (line_in[h] ^ line_ctl[h].inv)));
    end

    // run-length counter per shaper: every pulse must end after exactly PULSE_W cycles
    for (genvar p = 0; p < NP; p++) begin : g_pchk
        logic [RW-1:0] run_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (all_pulse[p]) begin
                run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
        a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(all_pulse[p]) |-> (run_q == RW'(PULSE_W)));
        a_r5_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
            all_pulse[p] |-> (run_q < RW'(PULSE_W)));
    end

endmodule

bind trig_route_mux trig_route_mux_chk #(
    .N_IN    (N_IN),
    .N_OUT   (N_OUT),
    .N_LINE  (N_LINE),
    .PULSE_W (PULSE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_space  (cfg_word[30]),
    .cfg_err    (cfg_err),
    .trig_in    (trig_in),
    .line_in    (line_in),
    .dbg_freeze (dbg_freeze),
    .mux_out    (mux_out),
    .line_out   (line_out),
    .mux_ctl    (mux_ctl),
    .mux_sel    (mux_sel),
    .line_ctl   (line_ctl),
    .mux_pulse  (mux_pulse),
    .line_pulse (line_pulse)
);

// File: tb/trig_route_mux_bench.sv
module trig_route_mux_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_word = '0;
    logic [7:0]  cfg_sel = '0;
    logic        cfg_en = 1'b0, cfg_inv = 1'b0, cfg_edge = 1'b0, cfg_frz = 1'b0;
    logic        cfg_err;
    logic [15:0] trig_in = '0;
    logic        dbg_freeze = 1'b0;
    logic [3:0]  mux_out;
    logic [3:0]  line_in = '0;
    logic [3:0]  line_out;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trig_route_mux u_trig_route_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_word   (cfg_word),
        .cfg_sel    (cfg_sel),
        .cfg_en     (cfg_en),
        .cfg_inv    (cfg_inv),
        .cfg_edge   (cfg_edge),
        .cfg_frz    (cfg_frz),
        .cfg_err    (cfg_err),
        .trig_in    (trig_in),
        .dbg_freeze (dbg_freeze),
        .mux_out    (mux_out),
        .line_in    (line_in),
        .line_out   (line_out)
    );

    typedef struct packed {
        logic [31:0] word;
        logic [7:0]  sel;
        logic        en, inv, edg, frz;
        logic [15:0] trig;
        logic        dbg;
        logic        xerr;
        logic [3:0]  xout;
    } vec_t;

    // group 3 addresses the multiplexer, group 5 the one-to-one lines
    localparam vec_t VECS [11] = '{
        '{32'h4000_0300, 8'd2,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0004, 1'b0, 1'b0, 4'b0001}, // R1 R3
        '{32'h4000_0301, 8'd7,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0004, 1'b0, 1'b0, 4'b0011}, // R3 invert
        '{32'h4000_0302, 8'd15, 1'b1, 1'b0, 1'b0, 1'b1, 16'h8004, 1'b0, 1'b0, 4'b0111}, // R6 armed, no freeze
        '{32'h4000_0303, 8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 16'h8005, 1'b1, 1'b0, 4'b1011}, // R6 frozen
        '{32'h0000_0300, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0004, 1'b0, 1'b1, 4'b0011}, // R8 bit30 clear
        '{32'h4000_0400, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b1, 4'b0110}, // R8 wrong group
        '{32'h4000_0304, 8'd9,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0085, 1'b0, 1'b1, 4'b1001}, // R8 index range
        '{32'h4000_0300, 8'd16, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 1'b0, 1'b1, 4'b1011}, // R8 select range
        '{32'h4000_0301, 8'd7,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 4'b0000}, // R2 disabled
        '{32'h4000_0302, 8'd15, 1'b1, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b1, 1'b0, 4'b0100}, // R6 not armed
        '{32'h4000_1300, 8'd2,  1'b1, 1'b0, 1'b0, 1'b0, 16'h8004, 1'b0, 1'b1, 4'b0101}  // R8 kind/group mismatch
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w, input logic [7:0] s,
                            input logic en, input logic inv, input logic edg, input logic frz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = w; cfg_sel = s;
        cfg_en = en; cfg_inv = inv; cfg_edge = edg; cfg_frz = frz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R2: reset state, all outputs disabled regardless of inputs
        trig_in = 16'hFFFF;
        line_in = 4'hF;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R2 reset mux_out", 32'(mux_out), 32'h0);
        chk("R2 reset line_out", 32'(line_out), 32'h0);
        chk("R2 reset err", 32'(cfg_err), 32'h0);
        trig_in = '0;
        line_in = '0;

        // table walk: level-mode routing, invert, freeze, refused writes (R10 throughout)
        foreach (VECS[vi]) begin
            do_write(VECS[vi].word, VECS[vi].sel, VECS[vi].en, VECS[vi].inv,
                     VECS[vi].edg, VECS[vi].frz);
            chk(VECS[vi].xerr ? "R8 err" : "R1 err", 32'(cfg_err), 32'(VECS[vi].xerr));
            trig_in = VECS[vi].trig;
            dbg_freeze = VECS[vi].dbg;
            #1;
            chk(VECS[vi].xerr ? "R8 R10 routing" : "R3 R10 routing", 32'(mux_out), 32'(VECS[vi].xout));
        end
        dbg_freeze = 1'b0;

        // R9: error flag holds without writes
        idle(3);
        chk("R9 err held", 32'(cfg_err), 32'h1);

        // R7: lines, select value ignored
        do_write(32'h4000_1500, 8'd200, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 line write accepted", 32'(cfg_err), 32'h0);
        do_write(32'h4000_1501, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        line_in = 4'b0000;
        #1;
        chk("R7 line invert", 32'(line_out), 32'b0010);
        line_in = 4'b0001;
        #1;
        chk("R7 line level", 32'(line_out), 32'b0011);
        do_write(32'h4000_1504, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R8 line index err", 32'(cfg_err), 32'h1);
        #1;
        chk("R8 line cfg kept", 32'(line_out), 32'b0011);
        do_write(32'h4000_1500, 8'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        dbg_freeze = 1'b1;
        #1;
        chk("R6 line frozen", 32'(line_out), 32'b0010);
        dbg_freeze = 1'b0;

        // R4 on a line in edge mode
        do_write(32'h4000_1502, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        idle(4);
        line_in[2] = 1'b1;
        idle(2);
        chk("R4 line before pulse", 32'(line_out[2]), 32'h0);
        idle(1);
        chk("R4 line pulse c1", 32'(line_out[2]), 32'h1);
        idle(1);
        chk("R4 line pulse c2", 32'(line_out[2]), 32'h1);
        idle(1);
        chk("R4 line pulse end", 32'(line_out[2]), 32'h0);

        // R4 on a multiplexer output in edge mode (output 3, input 0)
        trig_in = '0;
        do_write(32'h4000_0303, 8'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        idle(4);
        trig_in[0] = 1'b1;
        idle(2);
        chk("R4 mux before pulse", 32'(mux_out[3]), 32'h0);
        idle(1);
        chk("R4 mux pulse c1", 32'(mux_out[3]), 32'h1);
        idle(1);
        chk("R4 mux pulse c2", 32'(mux_out[3]), 32'h1);
        idle(1);
        chk("R4 mux pulse end", 32'(mux_out[3]), 32'h0);
        idle(2);
        chk("R4 level held gives one pulse", 32'(mux_out[3]), 32'h0);

        // R5: second rise detected inside the active pulse is dropped
        trig_in[0] = 1'b0;
        idle(6);
        trig_in[0] = 1'b1;
        idle(1);
        trig_in[0] = 1'b0;
        idle(1);
        trig_in[0] = 1'b1;
        idle(1);
        chk("R5 pulse c1", 32'(mux_out[3]), 32'h1);
        idle(1);
        chk("R5 pulse c2", 32'(mux_out[3]), 32'h1);
        idle(1);
        chk("R5 no extension", 32'(mux_out[3]), 32'h0);
        idle(1);
        chk("R5 no restart", 32'(mux_out[3]), 32'h0);
        idle(1);
        chk("R5 not queued", 32'(mux_out[3]), 32'h0);

        finish_run();
    end

endmodule